// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register set of a single DMA channel. A processor reaches it over a 32-bit word-only write/read port. Four words are decoded from address bits [3:2]: a control/status word at index 0, a transfer address at index 1, a byte count at index 2 and an address-extension word at index 3. The data mover, address translation and the attached peripheral sit outside this block. They consume the stored words and the side-band outputs.

The attached peripheral raises a level request. A request-tracking state machine turns the request edges into set and clear events on a pending bit. The pending bit is gated by an enable bit onto a registered interrupt output. Writes to the control word can also do three things. They can fire a one-clock reset pulse towards the peripheral. They change a DMA-enable level and a transfer-direction level that feed the peripheral. They follow a drain-bit rule.

The `NET_WINDOW` parameter selects the decode window. When it is set, the block answers a 32-byte window. Offsets 0x10 to 0x1F alias the four words, and anything above 0x1F reads zero and ignores writes. When it is clear, every address aliases onto the four words modulo 16.

The request-tracking machine has two states. `REQ_LOW` is the reset state. Its transition "request rise" goes to `REQ_HIGH` when the request is sampled high and sets the pending bit. From `REQ_HIGH`, the transition "request fall" returns to `REQ_LOW` when the request is sampled low and clears the pending bit.

Top module: `dma_csr_block`

## Requirements
- R1: After reset the control word reads 0xA0000000, the address, count and extension words read 0, and `irq_o`, `periph_reset_o`, `periph_dma_en_o` and `dma_to_mem_o` are low.
- R2: A write to index 1, 2 or 3 (address bits [3:2]) stores all 32 bits, and a read of that index returns them unchanged.
- R3: Control bits [31:25] and [2:0] ignore writes. Bits [31:28] always read 0xA, and bits 25, 2 and 1 always read 0.
- R4: Control bit 0 (pending) is set in the clock where the request is first sampled high and cleared in the clock where it is first sampled low. Writes never change it.
- R5: `irq_o` equals pending AND control bit 4 (interrupt enable), delayed by one clock.
- R6: A control write with bit 7 set drives `periph_reset_o` high for exactly the following clock. Bit 7 is stored as written.
- R7: For a control write with bit 7 clear: if bit 6 is set, bit 6 is stored as 0. If the whole written word is zero, bit 6 is stored as 1. Otherwise the writable bits are stored as written.
- R8: `periph_dma_en_o` follows stored control bit 9 and `dma_to_mem_o` follows stored control bit 8. Both change in the clock after the write.
- R9: Any write to index 1 sets control bit 26 (address loaded). Only reset clears it.
- R10: With `NET_WINDOW` set, offsets 0x10 to 0x1F alias the four words. Offsets above 0x1F read zero, and writes there change no register and fire no pulse.
- R11: With `NET_WINDOW` clear, every address selects the word given by bits [3:2], whatever its upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| periph_req | input | 1 | Level request from the peripheral |
| irq_o | output | 1 | Registered interrupt: pending AND enable |
| periph_reset_o | output | 1 | One-clock reset pulse to the peripheral |
| periph_dma_en_o | output | 1 | DMA-enable level to the peripheral |
| dma_to_mem_o | output | 1 | Transfer direction, high for writes to memory |

## Verification
Most faulty internal states show up at the ports within one clock. A bad read-only mask or drain rule appears on the next read of the control word. A mis-tracked request state appears as a wrong pending bit on the next read. The interrupt output repeats that error one clock later. A reset pulse that is missing or too long, or an enable level that does not follow bit 9, is seen at the peripheral outputs in the clock after the write. A decode error in the window or alias logic shows at once as wrong read data at an aliased or out-of-window address.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_REGS);
    localparam int unsigned WORD_LSB = 2;

    localparam logic [WORD_W-1:0] VERSION_WORD = 32'hA000_0000;
    localparam logic [WORD_W-1:0] FIXED_MASK   = 32'hFE00_0007;
    localparam logic [WORD_W-1:0] DRAIN_WORD   = 32'h0000_0040;

    localparam int unsigned BIT_PEND   = 0;
    localparam int unsigned BIT_IE     = 4;
    localparam int unsigned BIT_DRAIN  = 6;
    localparam int unsigned BIT_PRST   = 7;
    localparam int unsigned BIT_TOMEM  = 8;
    localparam int unsigned BIT_EN     = 9;
    localparam int unsigned BIT_LOADED = 26;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL  = 2'd0,
        IDX_ADDR  = 2'd1,
        IDX_COUNT = 2'd2,
        IDX_EXT   = 2'd3
    } reg_idx_e;

    typedef enum logic {
        REQ_LOW  = 1'b0,
        REQ_HIGH = 1'b1
    } req_state_e;
endpackage

// File: rtl/dma_csr_decode.sv
`timescale 1ns/1ps
module dma_csr_decode
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter bit          NET_WINDOW = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_idx_e          idx_o,
    output logic              hit_o
);
    localparam int unsigned NET_SPAN_W = 5;
    localparam int unsigned IDX_TOP    = WORD_LSB + IDX_W;

    assign idx_o = reg_idx_e'(addr_i[WORD_LSB +: IDX_W]);

    generate
        if (NET_WINDOW) begin : g_net
            // 32-byte window: upper address bits must be zero
            assign hit_o = (addr_i[ADDR_W-1:NET_SPAN_W] == '0);
            logic unused_net_bits;
            assign unused_net_bits = ^{addr_i[WORD_LSB-1:0], addr_i[NET_SPAN_W-1:IDX_TOP]};
        end else begin : g_narrow
            // every address aliases modulo 16
            assign hit_o = 1'b1;
            logic unused_narrow_bits;
            assign unused_narrow_bits = ^{addr_i[WORD_LSB-1:0], addr_i[ADDR_W-1:IDX_TOP]};
        end
    endgenerate
endmodule

// File: rtl/dma_csr_req_fsm.sv
`timescale 1ns/1ps
module dma_csr_req_fsm
    import dma_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o,
    output logic fall_o
);
    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            REQ_LOW: begin
                if (req_i) begin
                    state_d = REQ_HIGH;  // request rise
                    rise_o  = 1'b1;
                end
            end
            REQ_HIGH: begin
                if (!req_i) begin
                    state_d = REQ_LOW;   // request fall
                    fall_o  = 1'b1;
                end
            end
            default: state_d = REQ_LOW;
        endcase
    end
endmodule

// File: rtl/dma_csr_ctrl.sv
`timescale 1ns/1ps
module dma_csr_ctrl
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic              irq_o,
    output logic              prst_o
);
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] ctrl_d;
    logic [WORD_W-1:0] shaped;
    logic              irq_q;
    logic              prst_q;

    // drain-bit rule, skipped when a reset is requested
    always_comb begin
        shaped = wdata_i;
        if (!wdata_i[BIT_PRST]) begin
            if (wdata_i[BIT_DRAIN]) begin
                shaped[BIT_DRAIN] = 1'b0;
            end else if (wdata_i == '0) begin
                shaped = DRAIN_WORD;
            end
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl_i) begin
            ctrl_d = (ctrl_q & FIXED_MASK) | (shaped & ~FIXED_MASK) | VERSION_WORD;
        end
        if (wr_addr_i) begin
            ctrl_d[BIT_LOADED] = 1'b1;
        end
        if (rise_i) begin
            ctrl_d[BIT_PEND] = 1'b1;
        end else if (fall_i) begin
            ctrl_d[BIT_PEND] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= VERSION_WORD;
            irq_q  <= 1'b0;
            prst_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            irq_q  <= ctrl_q[BIT_PEND] & ctrl_q[BIT_IE];
            prst_q <= wr_ctrl_i & wdata_i[BIT_PRST];
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = irq_q;
    assign prst_o = prst_q;
endmodule

// File: rtl/dma_csr_block.sv
`timescale 1ns/1ps
module dma_csr_block
    import dma_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter bit          NET_WINDOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              periph_req,
    output logic              irq_o,
    output logic              periph_reset_o,
    output logic              periph_dma_en_o,
    output logic              dma_to_mem_o
);
    reg_idx_e                        idx;
    logic                            hit;
    logic [NUM_REGS-1:0]             wr_sel;
    logic                            req_rise;
    logic                            req_fall;
    logic [WORD_W-1:0]               ctrl_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] data_q;
    logic [WORD_W-1:0]               rd_word;

    dma_csr_decode #(
        .ADDR_W     (ADDR_W),
        .NET_WINDOW (NET_WINDOW)
    ) u_decode (
        .addr_i (bus_addr),
        .idx_o  (idx),
        .hit_o  (hit)
    );

    always_comb begin
        wr_sel = '0;
        if (bus_wr && hit) begin
            wr_sel[idx] = 1'b1;
        end
    end

    dma_csr_req_fsm u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (periph_req),
        .rise_o (req_rise),
        .fall_o (req_fall)
    );

    dma_csr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_sel[IDX_CTRL]),
        .wr_addr_i (wr_sel[IDX_ADDR]),
        .wdata_i   (bus_wdata),
        .rise_i    (req_rise),
        .fall_i    (req_fall),
        .ctrl_o    (ctrl_q),
        .irq_o     (irq_o),
        .prst_o    (periph_reset_o)
    );

    // plain data words at indices 1..NUM_REGS-1; entry 0 stays zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            for (int i = 1; i < NUM_REGS; i++) begin
                if (wr_sel[i]) begin
                    data_q[i] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        rd_word = data_q[idx];
        if (idx == IDX_CTRL) begin
            rd_word = ctrl_q;
        end
        bus_rdata = hit ? rd_word : '0;
    end

    assign periph_dma_en_o = ctrl_q[BIT_EN];
    assign dma_to_mem_o    = ctrl_q[BIT_TOMEM];
endmodule

// File: rtl/dma_csr_checker.sv
`timescale 1ns/1ps
module dma_csr_checker #(
    parameter int unsigned ADDR_W     = 8,
    parameter bit          NET_WINDOW = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  wd_prst,
    input logic                  wd_en,
    input logic                  periph_req,
    input logic                  irq_o,
    input logic                  periph_reset_o,
    input logic                  periph_dma_en_o,
    input logic [31:0]           ctrl_q,
    input logic [3:0][31:0]      data_q
);
    logic in_win;
    logic ctl_wr;
    logic adr_wr;
    logic miss_wr;

    assign in_win  = NET_WINDOW ? ({{(32-ADDR_W){1'b0}}, bus_addr} <= 32'h1F) : 1'b1;
    assign ctl_wr  = bus_wr && in_win && (bus_addr[3:2] == 2'd0);
    assign adr_wr  = bus_wr && in_win && (bus_addr[3:2] == 2'd1);
    assign miss_wr = bus_wr && !in_win;

    p_fixed_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[31:27] == 5'b10100 && !ctrl_q[25] && ctrl_q[2:1] == 2'b00);

    p_pend_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q[0]) |-> ctrl_q[0] == $past(periph_req));

    p_irq_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(ctrl_q[0] & ctrl_q[4]));

    p_prst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_reset_o |-> $past(ctl_wr && wd_prst));

    p_en_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_dma_en_o) |-> $past(ctl_wr && wd_en));

    p_en_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_dma_en_o) |-> $past(ctl_wr && !wd_en));

    p_loaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adr_wr |=> ctrl_q[26]);

    p_miss_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_wr |=> $stable(data_q) && $stable(ctrl_q[31:1]) && !periph_reset_o);
endmodule

bind dma_csr_block dma_csr_checker #(
    .ADDR_W     (ADDR_W),
    .NET_WINDOW (NET_WINDOW)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .wd_prst         (bus_wdata[dma_csr_pkg::BIT_PRST]),
    .wd_en           (bus_wdata[dma_csr_pkg::BIT_EN]),
    .periph_req      (periph_req),
    .irq_o           (irq_o),
    .periph_reset_o  (periph_reset_o),
    .periph_dma_en_o (periph_dma_en_o),
    .ctrl_q          (ctrl_q),
    .data_q          (data_q)
);

// File: tb/dma_csr_block_tb_top.sv
`timescale 1ns/1ps
module dma_csr_block_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req = 1'b0;
    logic        irq, prst, en, tomem;

    logic        n_wr = 1'b0;
    logic [7:0]  n_addr = '0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;
    logic        n_req = 1'b0;
    logic        n_irq, n_prst, n_en, n_tomem;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_csr_block #(.ADDR_W(8), .NET_WINDOW(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .periph_req(req), .irq_o(irq), .periph_reset_o(prst),
        .periph_dma_en_o(en), .dma_to_mem_o(tomem));

    dma_csr_block #(.ADDR_W(8), .NET_WINDOW(1'b0)) dut_n (
        .clk(clk), .rst_n(rst_n), .bus_wr(n_wr), .bus_addr(n_addr), .bus_wdata(n_wdata),
        .bus_rdata(n_rdata), .periph_req(n_req), .irq_o(n_irq), .periph_reset_o(n_prst),
        .periph_dma_en_o(n_en), .dma_to_mem_o(n_tomem));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic nwr32(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        n_wr = 1'b1; n_addr = a; n_wdata = d;
        @(negedge clk);
        n_wr = 1'b0;
    endtask

    task automatic nrdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        n_addr = a;
        #1;
        chk(tag, n_rdata, exp);
    endtask

    // expected control word after a write, from R3 and R7
    function automatic logic [31:0] ctrl_after(input logic [31:0] prev, input logic [31:0] v);
        logic [31:0] s;
        s = v;
        if (!v[7]) begin
            if (v[6]) s[6] = 1'b0;
            else if (v == 32'h0) s = 32'h40;
        end
        return (prev & 32'hFE00_0007) | (s & 32'h01FF_FFF8) | 32'hA000_0000;
    endfunction

    logic [31:0] exp_ctrl;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdchk("R1 ctrl", 8'h00, 32'hA000_0000);
        rdchk("R1 addr", 8'h04, 32'h0);
        rdchk("R1 count", 8'h08, 32'h0);
        rdchk("R1 ext", 8'h0C, 32'h0);
        chk("R1 outputs", {28'h0, irq, prst, en, tomem}, 32'h0);

        // R2 walking ones on the three data words; R9 after first address write
        for (int r = 1; r < 4; r++) begin
            for (int b = 0; b < 32; b++) begin
                wr32(8'(r * 4), 32'h1 << b);
                rdchk($sformatf("R2 idx%0d bit%0d", r, b), 8'(r * 4), 32'h1 << b);
            end
        end
        rdchk("R9 loaded after address write", 8'h00, 32'hA400_0000);
        wr32(8'h04, 32'hDEAD_BEEF);
        wr32(8'h08, 32'h0001_2345);
        wr32(8'h0C, 32'h5A5A_0000);
        rdchk("R2 addr", 8'h04, 32'hDEAD_BEEF);
        rdchk("R2 count", 8'h08, 32'h0001_2345);
        rdchk("R2 ext", 8'h0C, 32'h5A5A_0000);

        // R10 alias and out-of-window behaviour
        rdchk("R10 alias ctrl", 8'h10, 32'hA400_0000);
        rdchk("R10 alias addr", 8'h14, 32'hDEAD_BEEF);
        rdchk("R10 alias ext", 8'h1C, 32'h5A5A_0000);
        wr32(8'h18, 32'h0000_0077);
        rdchk("R10 alias write", 8'h08, 32'h0000_0077);
        for (int a = 32; a < 256; a += 4) begin
            wr32(8'(a), 32'hFFFF_FFFF);
            chk($sformatf("R10 no pulse at %0h", a), {31'h0, prst}, 32'h0);
            rdchk($sformatf("R10 zero read at %0h", a), 8'(a), 32'h0);
        end
        rdchk("R10 ctrl untouched", 8'h00, 32'hA400_0000);
        rdchk("R10 addr untouched", 8'h04, 32'hDEAD_BEEF);
        rdchk("R10 count untouched", 8'h08, 32'h0000_0077);
        rdchk("R10 ext untouched", 8'h0C, 32'h5A5A_0000);
        chk("R10 enable untouched", {31'h0, en}, 32'h0);

        // R3 R6 R7 R8 walking ones on the control word
        exp_ctrl = 32'hA400_0000;
        for (int b = 0; b < 32; b++) begin
            exp_ctrl = ctrl_after(exp_ctrl, 32'h1 << b);
            wr32(8'h00, 32'h1 << b);
            chk($sformatf("R6 pulse after bit%0d", b), {31'h0, prst}, {31'h0, b == 7});
            chk($sformatf("R8 enable after bit%0d", b), {30'h0, en, tomem},
                {30'h0, exp_ctrl[9], exp_ctrl[8]});
            rdchk($sformatf("R3 ctrl after bit%0d", b), 8'h00, exp_ctrl);
            @(negedge clk);
            chk($sformatf("R6 pulse gone after bit%0d", b), {31'h0, prst}, 32'h0);
        end
        wr32(8'h00, 32'h0);
        rdchk("R7 zero write sets drain", 8'h00, 32'hA400_0040);
        wr32(8'h00, 32'h0000_0040);
        rdchk("R7 drain write clears", 8'h00, 32'hA400_0000);
        wr32(8'h00, 32'h0000_00C0);
        chk("R6 pulse with drain", {31'h0, prst}, 32'h1);
        rdchk("R7 drain kept with reset bit", 8'h00, 32'hA400_00C0);
        wr32(8'h00, 32'hFFFF_FFFF);
        rdchk("R3 all-ones write", 8'h00, 32'hA5FF_FFF8);
        chk("R8 enable and direction high", {30'h0, en, tomem}, 32'h3);
        @(negedge clk);
        wr32(8'h00, 32'h0000_0100);
        chk("R8 enable low, direction high", {30'h0, en, tomem}, 32'h1);

        // R4 R5 interrupt path
        wr32(8'h00, 32'h0000_0010);
        rdchk("R5 enable set", 8'h00, 32'hA400_0010);
        req = 1'b1;
        @(negedge clk);
        rdchk("R4 pending on rise", 8'h00, 32'hA400_0011);
        chk("R5 irq lags one clock", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R5 irq raised", {31'h0, irq}, 32'h1);
        wr32(8'h00, 32'h0000_0011);
        rdchk("R4 write keeps pending", 8'h00, 32'hA400_0011);
        wr32(8'h00, 32'h0000_0000);
        chk("R5 irq still high one clock", {31'h0, irq}, 32'h1);
        rdchk("R4 pending survives zero write", 8'h00, 32'hA400_0041);
        @(negedge clk);
        chk("R5 irq dropped with enable", {31'h0, irq}, 32'h0);
        wr32(8'h00, 32'h0000_0010);
        chk("R5 irq lag after enable", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R5 irq back", {31'h0, irq}, 32'h1);
        req = 1'b0;
        @(negedge clk);
        rdchk("R4 pending cleared on fall", 8'h00, 32'hA400_0010);
        chk("R5 irq lag on fall", {31'h0, irq}, 32'h1);
        @(negedge clk);
        chk("R5 irq cleared", {31'h0, irq}, 32'h0);
        wr32(8'h00, 32'h0000_0020);
        req = 1'b1;
        repeat (3) @(negedge clk);
        rdchk("R4 pending without enable", 8'h00, 32'hA400_0021);
        chk("R5 no irq without enable", {31'h0, irq}, 32'h0);
        req = 1'b0;
        @(negedge clk);

        // R11 narrow-window instance
        nwr32(8'h28, 32'hCAFE_F00D);
        nrdchk("R11 alias base", 8'h08, 32'hCAFE_F00D);
        nrdchk("R11 alias high", 8'hF8, 32'hCAFE_F00D);
        nrdchk("R1 narrow addr untouched", 8'h04, 32'h0);
        nwr32(8'hE0, 32'h0000_0200);
        chk("R11 enable via alias", {31'h0, n_en}, 32'h1);
        nrdchk("R11 ctrl via alias", 8'h40, 32'hA000_0200);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule